// File: doc/BRIEF.md
# PTP Event Frame Classifier

This block watches received Ethernet frames as they stream past, one byte per accepted beat, with start-of-frame and end-of-frame markers. It picks out the few header bytes that identify a precision-time-protocol event message and, when the last byte of a frame is accepted, decides whether the capture logic should keep the timestamp it took for that frame. A positive decision is a single-cycle strobe in the cycle after the end-of-frame beat.

Four modes are selected on a plain control pin: stamp every frame; version-1 messages carried over UDP; version-2 messages carried either directly over Ethernet or over UDP with a chosen message type; and version-2 messages of any event type. A one-bit selector picks Sync or Delay_Req for the type-specific modes. Separate enables gate the Ethernet-type path and the UDP path, and an optional check also demands the event port as UDP source port. The input stream is valid/ready. The block never applies back-pressure: ready goes high in the first cycle after reset is released and stays high. A byte counts only in a cycle where valid and ready are both high. Bytes offered with valid low are ignored, whatever their markers say.

Top module: `ptp_event_classifier`

## Requirements
- R1: While reset is asserted `ts_qualify` and `s_ready` are low. From the first clock edge after reset is released, `s_ready` is high and stays high.
- R2: With `cfg_mode`=0 (stamp all), every frame raises `ts_qualify` for exactly one cycle after its end-of-frame beat. This holds whatever its length or content, and whatever the filter enables. A single-byte frame (start and end on the same beat) also qualifies, and back-to-back frames give back-to-back strobes.
- R3: Ethernet path: the frame carries EtherType 0x88F7 in bytes 12 (high) and 13 (low), and the PTP header starts at byte 14. This path is used only when `cfg_etype_en`=1. Any other EtherType never qualifies through it.
- R4: UDP path: bytes 12–13 are 0x0800, byte 14 is 0x45, protocol byte 23 is 17, and destination port bytes 36–37 are 319 (0x013F, high byte first). The PTP header starts at byte 42. This path is used only when `cfg_udp_en`=1.
- R5: With `cfg_src_port_chk`=1, the UDP path also needs source-port bytes 34–35 to equal 319. With the check off, the source port is not examined.
- R6: `cfg_mode`=1 (version 1) uses only the UDP path. It needs a version nibble (low nibble of PTP header byte 1) of 1, and a control byte at PTP header offset 32 equal to the selector: `cfg_msg_sel`=0 for Sync (control 0), 1 for Delay_Req (control 1).
- R7: `cfg_mode`=2 (version 2, chosen type) uses either path. It needs a version nibble of 2, and a message type equal to the selector: Sync 0, Delay_Req 1. The message type is the low nibble of PTP header byte 0, so the upper nibble is ignored.
- R8: `cfg_mode`=3 (version 2, any event) uses either path. It needs a version nibble of 2 and a message type of 0 to 3. Other types, such as 8, do not qualify.
- R9: With `cfg_etype_en`=0 and `cfg_udp_en`=0, no frame qualifies in modes 1 to 3.
- R10: A frame qualifies only if it reaches the last byte its path inspects. That means a length of at least 16 bytes for the Ethernet path, at least 44 bytes for version 2 over UDP, and at least 75 bytes for version 1.
- R11: An IPv4 header byte other than 0x45 (options present) never qualifies through the UDP path.
- R12: `ts_qualify` is high only in the cycle right after an accepted end-of-frame beat. Beats with `s_valid` low have no effect on position or decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Byte valid |
| s_ready | output | 1 | Byte accepted when high together with valid |
| s_data | input | 8 | Frame byte |
| s_sof | input | 1 | Marks first byte of a frame |
| s_eof | input | 1 | Marks last byte of a frame |
| cfg_mode | input | 2 | 0 all, 1 v1 UDP, 2 v2 chosen type, 3 v2 any event |
| cfg_msg_sel | input | 1 | 0 Sync, 1 Delay_Req |
| cfg_etype_en | input | 1 | Enables the Ethernet-type path |
| cfg_udp_en | input | 1 | Enables the UDP path |
| cfg_src_port_chk | input | 1 | Also require source port 319 |
| ts_qualify | output | 1 | One-cycle strobe: keep this frame's timestamp |

## Verification
The assertions assume that every frame opens with a start-of-frame beat and closes with exactly one end-of-frame beat. They also assume that the configuration pins are steady on the end-of-frame beat, since the checker's short-frame rule counts bytes from the most recent start marker. The stimulus always sends a complete frame with the markers on its first and last accepted byte, and changes configuration only between frames. Some frames include an idle cycle whose data is junk and whose end marker is set while valid is low, to show that such a cycle is not taken as a beat.

// File: rtl/ptpc_pkg.sv
package ptpc_pkg;

  typedef enum logic [1:0] {
    MODE_ALL      = 2'd0,
    MODE_V1_UDP   = 2'd1,
    MODE_V2_MATCH = 2'd2,
    MODE_V2_EVENT = 2'd3
  } mode_e;

  localparam logic [15:0] ETYPE_PTP  = 16'h88F7;
  localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
  localparam logic [7:0]  IPV4_VIHL  = 8'h45;
  localparam logic [7:0]  PROTO_UDP  = 8'd17;
  localparam logic [15:0] EVENT_PORT = 16'd319;

  localparam int unsigned ETYPE_OFS  = 12;
  localparam int unsigned L2_PTP_OFS = 14;
  localparam int unsigned IP_OFS     = 14;
  localparam int unsigned PROTO_OFS  = IP_OFS + 9;
  localparam int unsigned UDP_OFS    = IP_OFS + 20;
  localparam int unsigned UDP_PTP_OFS = UDP_OFS + 8;
  localparam int unsigned V1_CTL_REL = 32;

  // last byte needed by each path, plus one
  localparam int unsigned LEN_L2     = L2_PTP_OFS + 2;
  localparam int unsigned LEN_UDP_V2 = UDP_PTP_OFS + 2;
  localparam int unsigned LEN_UDP_V1 = UDP_PTP_OFS + V1_CTL_REL + 1;

  // captured field slots
  localparam int unsigned F_ETY_HI = 0;
  localparam int unsigned F_ETY_LO = 1;
  localparam int unsigned F_B14    = 2;
  localparam int unsigned F_B15    = 3;
  localparam int unsigned F_PROTO  = 4;
  localparam int unsigned F_SP_HI  = 5;
  localparam int unsigned F_SP_LO  = 6;
  localparam int unsigned F_DP_HI  = 7;
  localparam int unsigned F_DP_LO  = 8;
  localparam int unsigned F_U0     = 9;
  localparam int unsigned F_U1     = 10;
  localparam int unsigned F_UCTL   = 11;
  localparam int unsigned NUM_FIELDS = 12;

  function automatic int unsigned field_ofs(int unsigned slot);
    case (slot)
      F_ETY_HI: field_ofs = ETYPE_OFS;
      F_ETY_LO: field_ofs = ETYPE_OFS + 1;
      F_B14:    field_ofs = L2_PTP_OFS;
      F_B15:    field_ofs = L2_PTP_OFS + 1;
      F_PROTO:  field_ofs = PROTO_OFS;
      F_SP_HI:  field_ofs = UDP_OFS;
      F_SP_LO:  field_ofs = UDP_OFS + 1;
      F_DP_HI:  field_ofs = UDP_OFS + 2;
      F_DP_LO:  field_ofs = UDP_OFS + 3;
      F_U0:     field_ofs = UDP_PTP_OFS;
      F_U1:     field_ofs = UDP_PTP_OFS + 1;
      default:  field_ofs = UDP_PTP_OFS + V1_CTL_REL;
    endcase
  endfunction

endpackage

// File: rtl/ptpc_pos_counter.sv
module ptpc_pos_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  output logic [CNT_W-1:0] idx
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] next_pos;

  // position of the byte on the bus now
  assign idx = sof ? '0 : next_pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_pos <= '0;
    end else if (beat) begin
      if (idx == CNT_MAX) next_pos <= CNT_MAX;
      else                next_pos <= idx + CNT_W'(1);
    end
  end
endmodule

// File: rtl/ptpc_field_grab.sv
module ptpc_field_grab #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned NF    = ptpc_pkg::NUM_FIELDS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                beat,
  input  logic [CNT_W-1:0]    idx,
  input  logic [7:0]          data,
  output logic [NF-1:0][7:0]  view
);
  for (genvar g = 0; g < NF; g++) begin : g_slot
    localparam int unsigned OFS = ptpc_pkg::field_ofs(g);
    localparam logic [CNT_W-1:0] OFS_W = CNT_W'(OFS);
    logic [7:0] held;
    logic       here;

    assign here = beat && (idx == OFS_W);

    always_ff @(posedge clk) begin
      if (!rst_n)    held <= '0;
      else if (here) held <= data;
    end

    // bypass so the end-of-frame byte is usable in its own cycle
    assign view[g] = here ? data : held;
  end
endmodule

// File: rtl/ptpc_match.sv
module ptpc_match #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned NF    = ptpc_pkg::NUM_FIELDS
) (
  input  logic [NF-1:0][7:0] view,
  input  logic [CNT_W:0]     len,
  input  logic [1:0]         mode,
  input  logic               msg_sel,
  input  logic               etype_en,
  input  logic               udp_en,
  input  logic               src_chk,
  output logic               hit
);
  import ptpc_pkg::*;

  localparam int unsigned LW = CNT_W + 1;
  localparam logic [LW-1:0] NEED_L2 = LW'(LEN_L2);
  localparam logic [LW-1:0] NEED_V2 = LW'(LEN_UDP_V2);
  localparam logic [LW-1:0] NEED_V1 = LW'(LEN_UDP_V1);

  logic [15:0] etype, sport, dport;
  logic        ip_ok, l2_path, udp_v2_path, udp_v1_path;
  logic        v2_l2, v2_udp, v1_hit;
  mode_e       m;

  assign m     = mode_e'(mode);
  assign etype = {view[F_ETY_HI], view[F_ETY_LO]};
  assign sport = {view[F_SP_HI], view[F_SP_LO]};
  assign dport = {view[F_DP_HI], view[F_DP_LO]};

  assign ip_ok = udp_en && (etype == ETYPE_IPV4) && (view[F_B14] == IPV4_VIHL) &&
                 (view[F_PROTO] == PROTO_UDP) && (dport == EVENT_PORT) &&
                 (!src_chk || (sport == EVENT_PORT));

  assign l2_path     = etype_en && (etype == ETYPE_PTP) && (len >= NEED_L2);
  assign udp_v2_path = ip_ok && (len >= NEED_V2);
  assign udp_v1_path = ip_ok && (len >= NEED_V1);

  function automatic logic v2_ok(input logic [7:0] b0, input logic [7:0] b1,
                                 input mode_e md, input logic sel);
    logic type_ok;
    if (md == MODE_V2_EVENT) type_ok = (b0[3:0] < 4'd4);
    else                     type_ok = (b0[3:0] == {3'b000, sel});
    return (b1[3:0] == 4'd2) && type_ok;
  endfunction

  assign v2_l2  = l2_path && v2_ok(view[F_B14], view[F_B15], m, msg_sel);
  assign v2_udp = udp_v2_path && v2_ok(view[F_U0], view[F_U1], m, msg_sel);
  assign v1_hit = udp_v1_path && (view[F_U1][3:0] == 4'd1) &&
                  (view[F_UCTL] == {7'd0, msg_sel});

  always_comb begin
    case (m)
      MODE_ALL:    hit = 1'b1;
      MODE_V1_UDP: hit = v1_hit;
      default:     hit = v2_l2 || v2_udp;
    endcase
  end
endmodule

// File: rtl/ptp_event_classifier.sv
module ptp_event_classifier #(
  parameter int unsigned CNT_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [7:0] s_data,
  input  logic       s_sof,
  input  logic       s_eof,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_msg_sel,
  input  logic       cfg_etype_en,
  input  logic       cfg_udp_en,
  input  logic       cfg_src_port_chk,
  output logic       ts_qualify
);
  localparam int unsigned NF = ptpc_pkg::NUM_FIELDS;

  logic                beat, hit, ready_q, qual_q;
  logic [CNT_W-1:0]    idx;
  logic [CNT_W:0]      len;
  logic [NF-1:0][7:0]  view;

  assign beat = s_valid && ready_q;
  assign len  = {1'b0, idx} + (CNT_W+1)'(1);

  ptpc_pos_counter #(.CNT_W(CNT_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(s_sof), .idx(idx)
  );

  ptpc_field_grab #(.CNT_W(CNT_W), .NF(NF)) u_grab (
    .clk(clk), .rst_n(rst_n), .beat(beat), .idx(idx), .data(s_data), .view(view)
  );

  ptpc_match #(.CNT_W(CNT_W), .NF(NF)) u_match (
    .view(view), .len(len), .mode(cfg_mode), .msg_sel(cfg_msg_sel),
    .etype_en(cfg_etype_en), .udp_en(cfg_udp_en), .src_chk(cfg_src_port_chk),
    .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      qual_q  <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      qual_q  <= beat && s_eof && hit;
    end
  end

  assign s_ready    = ready_q;
  assign ts_qualify = qual_q;
endmodule

// File: rtl/ptpc_checker.sv
module ptpc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       s_valid,
  input logic       s_ready,
  input logic       s_sof,
  input logic       s_eof,
  input logic [1:0] cfg_mode,
  input logic       cfg_etype_en,
  input logic       cfg_udp_en,
  input logic       ts_qualify
);
  logic        acc;
  logic [15:0] seen, frame_len;

  assign acc       = s_valid && s_ready;
  assign frame_len = s_sof ? 16'd1 : seen + 16'd1;

  always_ff @(posedge clk) begin
    if (!rst_n)   seen <= '0;
    else if (acc) seen <= frame_len;
  end

  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> s_ready); // R1
  AST_STROBE_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    ts_qualify |-> $past(acc && s_eof)); // R12
  AST_ALL_MODE_STAMPS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && s_eof && cfg_mode == 2'd0) |=> ts_qualify); // R2
  AST_FILTERS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && s_eof && cfg_mode != 2'd0 && !cfg_etype_en && !cfg_udp_en) |=> !ts_qualify); // R9
  AST_SHORT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && s_eof && cfg_mode != 2'd0 && frame_len < 16'd16) |=> !ts_qualify); // R10
  AST_V1_NEEDS_UDP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && s_eof && cfg_mode == 2'd1 && !cfg_udp_en) |=> !ts_qualify); // R6
endmodule

bind ptp_event_classifier ptpc_checker u_chk (.*);

// File: tb/ptp_event_classifier_bench.sv
module ptp_event_classifier_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_sof = 1'b0, s_eof = 1'b0;
  logic [7:0] s_data = '0;
  logic [1:0] cfg_mode = '0;
  logic cfg_msg_sel = 1'b0, cfg_etype_en = 1'b0, cfg_udp_en = 1'b0, cfg_src_port_chk = 1'b0;
  logic s_ready, ts_qualify;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptp_event_classifier u_ptp_event_classifier (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_sof(s_sof), .s_eof(s_eof), .cfg_mode(cfg_mode), .cfg_msg_sel(cfg_msg_sel),
    .cfg_etype_en(cfg_etype_en), .cfg_udp_en(cfg_udp_en),
    .cfg_src_port_chk(cfg_src_port_chk), .ts_qualify(ts_qualify)
  );

  // kind: 0 Ethernet PTP, 1 UDP good, 2 UDP bad source port, 3 IHL 0x46,
  //       4 EtherType 0x86DD, 5 UDP bad destination port
  typedef struct packed {
    logic [2:0] kind;
    logic [1:0] mode;
    logic       sel, et, udp, src;
    logic [3:0] typ, ver;
    logic [7:0] ctl, len;
    logic       gap, exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{3'd0,2'd2,1'b0,1'b1,1'b1,1'b0,4'd0,4'd2,8'd0,8'd60,1'b0,1'b1,4'd3},  // R3
    '{3'd0,2'd2,1'b1,1'b1,1'b1,1'b0,4'd0,4'd2,8'd0,8'd60,1'b1,1'b0,4'd7},  // R7
    '{3'd0,2'd2,1'b1,1'b1,1'b1,1'b0,4'd1,4'd2,8'd0,8'd60,1'b0,1'b1,4'd7},  // R7
    '{3'd0,2'd2,1'b0,1'b0,1'b1,1'b0,4'd0,4'd2,8'd0,8'd60,1'b0,1'b0,4'd3},  // R3
    '{3'd1,2'd2,1'b0,1'b0,1'b1,1'b0,4'd0,4'd2,8'd0,8'd60,1'b1,1'b1,4'd4},  // R4
    '{3'd1,2'd2,1'b0,1'b1,1'b0,1'b0,4'd0,4'd2,8'd0,8'd60,1'b0,1'b0,4'd4},  // R4
    '{3'd5,2'd2,1'b0,1'b1,1'b1,1'b0,4'd0,4'd2,8'd0,8'd60,1'b0,1'b0,4'd4},  // R4
    '{3'd1,2'd3,1'b1,1'b1,1'b1,1'b0,4'd3,4'd2,8'd0,8'd60,1'b0,1'b1,4'd8},  // R8
    '{3'd1,2'd3,1'b0,1'b1,1'b1,1'b0,4'd8,4'd2,8'd0,8'd60,1'b0,1'b0,4'd8},  // R8
    '{3'd0,2'd3,1'b0,1'b1,1'b1,1'b0,4'd2,4'd2,8'd0,8'd60,1'b1,1'b1,4'd8},  // R8
    '{3'd1,2'd1,1'b0,1'b1,1'b1,1'b0,4'd0,4'd1,8'd0,8'd90,1'b0,1'b1,4'd6},  // R6
    '{3'd1,2'd1,1'b0,1'b1,1'b1,1'b0,4'd0,4'd1,8'd1,8'd90,1'b0,1'b0,4'd6},  // R6
    '{3'd1,2'd1,1'b1,1'b1,1'b1,1'b0,4'd0,4'd1,8'd1,8'd90,1'b1,1'b1,4'd6},  // R6
    '{3'd0,2'd1,1'b0,1'b1,1'b1,1'b0,4'd0,4'd1,8'd0,8'd90,1'b0,1'b0,4'd6},  // R6
    '{3'd1,2'd2,1'b0,1'b1,1'b1,1'b0,4'd0,4'd1,8'd0,8'd60,1'b0,1'b0,4'd7},  // R7
    '{3'd2,2'd2,1'b0,1'b1,1'b1,1'b1,4'd0,4'd2,8'd0,8'd60,1'b0,1'b0,4'd5},  // R5
    '{3'd2,2'd2,1'b0,1'b1,1'b1,1'b0,4'd0,4'd2,8'd0,8'd60,1'b0,1'b1,4'd5},  // R5
    '{3'd1,2'd2,1'b0,1'b1,1'b1,1'b1,4'd0,4'd2,8'd0,8'd60,1'b0,1'b1,4'd5},  // R5
    '{3'd3,2'd3,1'b0,1'b1,1'b1,1'b0,4'd0,4'd2,8'd0,8'd60,1'b0,1'b0,4'd11}, // R11
    '{3'd4,2'd3,1'b0,1'b1,1'b1,1'b0,4'd0,4'd2,8'd0,8'd60,1'b0,1'b0,4'd3},  // R3
    '{3'd4,2'd0,1'b0,1'b0,1'b0,1'b0,4'd0,4'd0,8'd0,8'd2,1'b0,1'b1,4'd2},   // R2
    '{3'd1,2'd3,1'b0,1'b0,1'b0,1'b0,4'd0,4'd2,8'd0,8'd60,1'b0,1'b0,4'd9},  // R9
    '{3'd0,2'd3,1'b0,1'b0,1'b0,1'b0,4'd0,4'd2,8'd0,8'd60,1'b0,1'b0,4'd9},  // R9
    '{3'd1,2'd1,1'b0,1'b1,1'b1,1'b0,4'd0,4'd1,8'd0,8'd74,1'b0,1'b0,4'd10}, // R10
    '{3'd1,2'd1,1'b0,1'b1,1'b1,1'b0,4'd0,4'd1,8'd0,8'd75,1'b0,1'b1,4'd10}, // R10
    '{3'd0,2'd2,1'b0,1'b1,1'b1,1'b0,4'd0,4'd2,8'd0,8'd15,1'b0,1'b0,4'd10}, // R10
    '{3'd0,2'd2,1'b0,1'b1,1'b1,1'b0,4'd0,4'd2,8'd0,8'd16,1'b0,1'b1,4'd10}, // R10
    '{3'd1,2'd2,1'b0,1'b1,1'b1,1'b0,4'd0,4'd2,8'd0,8'd43,1'b0,1'b0,4'd10}, // R10
    '{3'd1,2'd2,1'b0,1'b1,1'b1,1'b0,4'd0,4'd2,8'd0,8'd44,1'b1,1'b1,4'd10}, // R10
    '{3'd1,2'd0,1'b0,1'b0,1'b0,1'b0,4'd8,4'd2,8'd0,8'd60,1'b0,1'b1,4'd2}   // R2
  };

  logic [7:0] fr [0:127];

  task automatic check(input bit ok, input int req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic build(input vec_t v);
    int p;
    for (int i = 0; i < 128; i++) fr[i] = (i < 12) ? 8'(i + 1) : 8'h00;
    p = 14;
    case (v.kind)
      3'd0: begin fr[12] = 8'h88; fr[13] = 8'hF7; end
      3'd4: begin fr[12] = 8'h86; fr[13] = 8'hDD; end
      default: begin
        fr[12] = 8'h08; fr[13] = 8'h00;
        fr[14] = (v.kind == 3'd3) ? 8'h46 : 8'h45;
        fr[23] = 8'd17;
        fr[34] = 8'h01; fr[35] = (v.kind == 3'd2) ? 8'h40 : 8'h3F;
        fr[36] = 8'h01; fr[37] = (v.kind == 3'd5) ? 8'h40 : 8'h3F;
        p = 42;
      end
    endcase
    fr[p]      = {4'h3, v.typ};
    fr[p + 1]  = {4'h0, v.ver};
    fr[p + 32] = v.ctl;
  endtask

  task automatic send(input int len, input bit gap);
    for (int i = 0; i < len; i++) begin
      if (gap && i == 5) begin
        @(negedge clk);
        s_valid = 1'b0; s_data = 8'hFF; s_sof = 1'b1; s_eof = 1'b1;
      end
      @(negedge clk);
      s_valid = 1'b1; s_data = fr[i]; s_sof = (i == 0); s_eof = (i == len - 1);
    end
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(ts_qualify == 1'b0, 1, ts_qualify, 0, "qualify during reset");
    check(s_ready == 1'b0, 1, s_ready, 0, "ready during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(s_ready == 1'b1, 1, s_ready, 1, "ready after reset");
    check(ts_qualify == 1'b0, 1, ts_qualify, 0, "qualify after reset");

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = VECS[k];
      build(v);
      cfg_mode = v.mode; cfg_msg_sel = v.sel; cfg_etype_en = v.et;
      cfg_udp_en = v.udp; cfg_src_port_chk = v.src;
      send(v.len, v.gap);
      check(ts_qualify == v.exp, v.req, ts_qualify, v.exp, $sformatf("vector %0d strobe", k));
      @(negedge clk);
      check(ts_qualify == 1'b0, 12, ts_qualify, 0, $sformatf("vector %0d one cycle", k));
    end

    // R2 / R12: back-to-back single-byte frames in stamp-all mode
    cfg_mode = 2'd0; cfg_etype_en = 1'b0; cfg_udp_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (i > 0) check(ts_qualify == 1'b1, 2, ts_qualify, 1, "back-to-back strobe");
      s_valid = 1'b1; s_sof = 1'b1; s_eof = 1'b1; s_data = 8'h00;
    end
    @(negedge clk);
    check(ts_qualify == 1'b1, 2, ts_qualify, 1, "last back-to-back strobe");
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
    @(negedge clk);
    check(ts_qualify == 1'b0, 12, ts_qualify, 0, "strobe ends");

    // R12: end marker with valid low is not a beat
    repeat (2) begin
      @(negedge clk);
      s_valid = 1'b0; s_sof = 1'b1; s_eof = 1'b1;
    end
    @(negedge clk);
    s_sof = 1'b0; s_eof = 1'b0;
    check(ts_qualify == 1'b0, 12, ts_qualify, 0, "eof without valid");
    @(negedge clk);
    check(ts_qualify == 1'b0, 12, ts_qualify, 0, "eof without valid later");

    finish_run();
  end
endmodule